// File: doc/BRIEF.md
# External Interrupt Line Converter

This block accepts a parameterised number of asynchronous external interrupt pins, from one to 32, and presents each of them to a downstream interrupt controller as an active-high, level-type request. Software picks the trigger for each line. A line is either level-sensitive, with an active-high or active-low sense, or edge-sensitive, catching either rising or falling transitions. An edge is held in a per-line pending flag until software acknowledges it.

Each line has its own mask bit. Software sets a mask bit with a write-one enable strobe and clears it with a write-one disable strobe, so one line can change without a read-modify-write of the others. All registers sit on a simple synchronous bus. Writes take effect at the clock edge and reads are combinational from the address. Configuration bits for lines that are not built always read as zero. Software can therefore write all ones to the mode register and read it back to find out how many lines exist.

Top module: `ext_irq_conv`

## Requirements
- R1: After reset every line is masked and set to edge mode, falling edge, active-low, with nothing pending. The mask (0x08), pending (0x0C), mode (0x14), edge (0x18) and level (0x1C) words all read zero, and every request output is low.
- R2: Mode bits at indices at or above NUM_LINES ignore writes and read zero. After all ones are written to 0x14, it reads back a word whose highest set bit is bit NUM_LINES-1.
- R3: Writing to 0x00 sets the mask bits of the lines whose data bits are one. Writing to 0x04 clears them. Zero data bits change nothing. The current mask state reads at 0x08, with bit i set meaning line i is enabled.
- R4: Request output i equals pending bit i ANDed with mask bit i. A masked line drives its output low whatever its pending state.
- R5: A line with mode bit 0 and edge bit 0 latches pending on a high-to-low transition of its pin and does not latch on a low-to-high transition.
- R6: With edge bit 1 the line latches on a low-to-high transition. A latched edge is captured even while the line is masked. It stays set until a one is written to that bit of the clear word at 0x10.
- R7: If a selected edge and a clear of the same line fall in the same cycle, the pending bit ends up set.
- R8: A line with mode bit 1 is pending while its pin sits at the active level: high when its level bit is 1, low when it is 0. Writes to the clear word do not affect it.
- R9: Pending state reads at 0x0C with bit i for line i. The write-only words 0x00, 0x04 and 0x10 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | NUM_LINES | Active-high level requests to the interrupt controller |

## Verification
The assertions assume the bus drives bus_addr and bus_wdata to known values whenever bus_we is high. They also assume pin transitions are at least a few cycles apart, so that each change passes cleanly through the two-stage synchroniser. The bench changes pins and bus inputs only on falling clock edges. It waits four cycles after a pin change before it samples, except in the race test, which lines up a clear write with the cycle in which the synchronised edge is detected.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFF_EN   = 5'h00,
        OFF_DIS  = 5'h04,
        OFF_MSK  = 5'h08,
        OFF_PND  = 5'h0C,
        OFF_CLR  = 5'h10,
        OFF_MODE = 5'h14,
        OFF_EDGE = 5'h18,
        OFF_LVL  = 5'h1C
    } reg_off_e;

    typedef struct packed {
        logic lvl_mode;   // 1: level-sensitive, 0: edge-sensitive
        logic rise;       // edge mode: 1 rising, 0 falling
        logic act_high;   // level mode: 1 active-high, 0 active-low
    } line_cfg_t;

    function automatic logic edge_seen(input logic rise, input logic cur, input logic prev);
        return rise ? (cur & ~prev) : (~cur & prev);
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/eic_line.sv
module eic_line
    import eic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_s,
    input  line_cfg_t cfg,
    input  logic      clr,
    output logic      pend_o
);
    logic prev_q;
    logic latch_q;
    logic hit;

    assign hit = !cfg.lvl_mode && edge_seen(cfg.rise, pin_s, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            latch_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (cfg.lvl_mode) begin
                latch_q <= 1'b0;
            end else begin
                latch_q <= hit | (latch_q & ~clr);
            end
        end
    end

    assign pend_o = cfg.lvl_mode ? (pin_s == cfg.act_high) : latch_q;

    // R6: a latched edge survives until cleared
    assert_edge_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg.lvl_mode && latch_q && !clr) |=> latch_q);

    // R7: a new edge beats a simultaneous clear
    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> latch_q);
endmodule

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [REG_W-1:0]      wdata,
    input  logic [NUM_LINES-1:0]  pend_i,
    output logic [REG_W-1:0]      rdata,
    output logic [NUM_LINES-1:0]  en_o,
    output line_cfg_t             cfg_o [NUM_LINES],
    output logic [NUM_LINES-1:0]  clr_o
);
    logic [NUM_LINES-1:0] en_q, mode_q, edge_q, lvl_q;
    logic [NUM_LINES-1:0] wbits;

    assign wbits = wdata[NUM_LINES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
            edge_q <= '0;
            lvl_q  <= '0;
        end else if (we) begin
            case (addr)
                OFF_EN:   en_q   <= en_q | wbits;
                OFF_DIS:  en_q   <= en_q & ~wbits;
                OFF_MODE: mode_q <= wbits;
                OFF_EDGE: edge_q <= wbits;
                OFF_LVL:  lvl_q  <= wbits;
                default:  ;
            endcase
        end
    end

    assign clr_o = (we && addr == OFF_CLR) ? wbits : '0;
    assign en_o  = en_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
        assign cfg_o[i] = '{lvl_mode: mode_q[i], rise: edge_q[i], act_high: lvl_q[i]};
    end

    always_comb begin
        case (addr)
            OFF_MSK:  rdata = REG_W'(en_q);
            OFF_PND:  rdata = REG_W'(pend_i);
            OFF_MODE: rdata = REG_W'(mode_q);
            OFF_EDGE: rdata = REG_W'(edge_q);
            OFF_LVL:  rdata = REG_W'(lvl_q);
            default:  rdata = '0;
        endcase
    end

    // R3: enable strobe sets, disable strobe clears
    assert_enable_set_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFF_EN && wdata[0]) |=> en_o[0]);
    assert_disable_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFF_DIS && wdata[0]) |=> !en_o[0]);
endmodule

// File: rtl/ext_irq_conv.sv
module ext_irq_conv
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic                 bus_we,
    input  logic [4:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] irq_o
);
    logic [NUM_LINES-1:0] pins_s, pend, en, clr;
    line_cfg_t            cfg [NUM_LINES];

    eic_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .async_i(pins_i), .sync_o(pins_s)
    );

    eic_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .pend_i(pend), .rdata(bus_rdata), .en_o(en), .cfg_o(cfg), .clr_o(clr)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        eic_line u_line (
            .clk(clk), .rst(rst), .pin_s(pins_s[i]), .cfg(cfg[i]),
            .clr(clr[i]), .pend_o(pend[i])
        );
    end

    assign irq_o = pend & en;

    // R4: a line masked and not being enabled cannot request next cycle
    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!en[0] && !(bus_we && bus_addr == OFF_EN && bus_wdata[0])) |=> !irq_o[0]);
endmodule

// File: tb/ext_irq_conv_test.sv
module ext_irq_conv_test;
    localparam int PERIOD = 10;
    localparam int N = 8;

    logic         clk = 0;
    logic         rst = 1;
    logic [N-1:0] pins = '1;
    logic         we = 0;
    logic [4:0]   addr = 0;
    logic [31:0]  wdata = 0;
    logic [31:0]  rdata;
    logic [N-1:0] irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    ext_irq_conv #(.NUM_LINES(N)) uut (
        .clk(clk), .rst(rst), .pins_i(pins), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    // level-mode vectors: {pins, expected pending}, level word = 0x0F
    localparam logic [7:0] VEC [4][2] = '{
        '{8'h00, 8'hF0},
        '{8'hFF, 8'h0F},
        '{8'hA5, 8'h55},
        '{8'h3C, 8'hCC}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd(5'h08, v); check("R1 mask", v, 0);
        rd(5'h0C, v); check("R1 pend", v, 0);
        rd(5'h14, v); check("R1 mode", v, 0);
        rd(5'h18, v); check("R1 edge", v, 0);
        rd(5'h1C, v); check("R1 level", v, 0);
        check("R1 irq", 32'(irq), 0);

        // R2 line discovery
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, v); check("R2 mode readback", v, 32'h0000_00FF);
        wr(5'h14, 0);

        // R3 enable / disable strobes
        wr(5'h00, 32'h05); rd(5'h08, v); check("R3 enable", v, 32'h05);
        wr(5'h00, 32'h00); rd(5'h08, v); check("R3 enable zero", v, 32'h05);
        wr(5'h04, 32'h04); rd(5'h08, v); check("R3 disable", v, 32'h01);
        wr(5'h04, 32'h00); rd(5'h08, v); check("R3 disable zero", v, 32'h01);

        // R9 write-only words read zero
        rd(5'h00, v); check("R9 en reads 0", v, 0);
        rd(5'h10, v); check("R9 clr reads 0", v, 0);

        // R5 falling edge on enabled line 0
        @(negedge clk); pins[0] = 0; settle();
        rd(5'h0C, v); check("R5 falling latched", v, 32'h01);
        check("R4 irq line0", 32'(irq), 32'h01);
        @(negedge clk); pins[0] = 1; settle();
        rd(5'h0C, v); check("R5 rising ignored", v, 32'h01);

        // R6/R4 masked line 1 still latches
        @(negedge clk); pins[1] = 0; settle();
        rd(5'h0C, v); check("R6 masked latch", v, 32'h03);
        check("R4 masked no irq", 32'(irq), 32'h01);
        @(negedge clk); pins[1] = 1;
        wr(5'h10, 32'h03); settle();
        rd(5'h0C, v); check("R6 cleared", v, 0);

        // R6 rising edge on line 2
        wr(5'h18, 32'h04); wr(5'h00, 32'h04);
        @(negedge clk); pins[2] = 0; settle();
        rd(5'h0C, v); check("R6 falling ignored", v, 0);
        @(negedge clk); pins[2] = 1; settle();
        rd(5'h0C, v); check("R6 rising latched", v, 32'h04);
        check("R4 irq line2", 32'(irq), 32'h04);

        // R7 edge and clear in the same cycle
        @(negedge clk); pins[2] = 0; settle();
        rd(5'h0C, v); check("R6 held", v, 32'h04);
        @(negedge clk); pins[2] = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); we = 1; addr = 5'h10; wdata = 32'h04;
        @(negedge clk); we = 0;
        rd(5'h0C, v); check("R7 edge wins", v, 32'h04);
        wr(5'h10, 32'h04);
        rd(5'h0C, v); check("R7 later clear", v, 0);

        // R8 level mode table
        wr(5'h14, 32'hFF); wr(5'h1C, 32'h0F); wr(5'h00, 32'hFF);
        foreach (VEC[k]) begin
            @(negedge clk); pins = VEC[k][0]; settle();
            rd(5'h0C, v); check("R8 level pend", v, 32'(VEC[k][1]));
            check("R4 level irq", 32'(irq), 32'(VEC[k][1]));
        end
        wr(5'h10, 32'hFF);
        rd(5'h0C, v); check("R8 clear no effect", v, 32'hCC);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule